// File: doc/BRIEF.md
# SPI Interrupt Status Controller

This block keeps the character-level status of an SPI controller and turns it into a single interrupt level. The serial engine hands it a one-cycle transfer-complete pulse together with the byte it has shifted in. The block keeps that byte in a receive holding register and raises a receive-full flag and a transmit-empty flag. It also records four kinds of error as sticky bits: transmit underrun, collision, abort and receive overrun.

Software works through a small register port. Address 0 reads the received byte, and writing it loads the next transmit byte. Address 1 reads status, and writing it clears error bits with write-1-to-clear.

A 2-bit mode input chooses the operation. In the off mode the interface ignores character traffic, and a baud-generator timeout can act as a plain timer interrupt. In transmit-only mode received bytes are still kept but never interrupt. The full modes do everything.

Top module: `spi_irq_status`

## Requirements
- R1: In a mode other than 00, a `xfer_done` pulse stores `shift_data` into the receive register and sets receive-full at the next clock edge.
- R2: Reading address 0 clears receive-full at the next edge. If a transfer completes in the same cycle, the new character wins and receive-full stays set.
- R3: The data interrupt source (receive-full, or transmit-empty) drives `irq` only when mode is not 00 and `data_irq_en` is 1.
- R4: In mode 10 (transmit-only), a received byte is still stored and readable. Receive-full never drives `irq`, and overrun is never recorded.
- R5: Reset leaves transmit-empty at 1 and every other flag at 0. A completed transfer sets receive-full and transmit-empty at the same edge. A write to address 0 clears transmit-empty unless a transfer completes in that cycle.
- R6: Status byte layout at address 1: bit 7 is transmit-empty and bit 6 is receive-full. Bit 3 is underrun, bit 2 collision, bit 1 abort and bit 0 overrun; the other bits read 0. The error bits are sticky. Their OR drives `irq` whenever mode is not 00, whatever `data_irq_en` is. Writing 1 to an error bit at address 1 clears it.
- R7: An error event and a write-1-to-clear of the same bit in one cycle leave the bit set.
- R8: In modes 01 and 11, a completed transfer while receive-full is set, and with no address-0 read in that cycle, sets the overrun bit.
- R9: In mode 00 with `timer_en` at 1, a `brg_timeout` pulse makes a timer request pending, and `irq` rises at the next edge. No status bit changes. The request clears on a status read (the timeout wins if both happen in one cycle) or when `timer_en` is 0.
- R10: `irq` is a level that stays high while any enabled source is pending and drops in the cycle its last source clears.
- R11: In mode 00, transfer-complete and error-event inputs change no flag and no stored data.
- R12: `rdata` is registered. It shows the addressed value the cycle after a read, addresses 2 and 3 read 0, and it holds when there is no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 off, 01/11 full, 10 transmit-only |
| data_irq_en | input | 1 | Enables the receive/transmit data interrupt |
| timer_en | input | 1 | Enables the baud-timer interrupt in mode 00 |
| xfer_done | input | 1 | One-cycle end-of-character pulse |
| shift_data | input | 8 | Received byte from the shifter |
| underrun_evt | input | 1 | Transmit underrun event |
| collision_evt | input | 1 | Collision event |
| abort_evt | input | 1 | Abort event |
| brg_timeout | input | 1 | Baud generator timeout pulse |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt level |

## Verification
Every flag, error bit and the timer request update at the first clock edge after their stimulus. `irq` is combinational from those registers and the mode and enable inputs, so it is valid in the cycle after that edge. Read data appears one edge after the read strobe. The bench drives inputs on the falling edge and advances a reference model at the rising edge. It then compares `irq` and `rdata` at the following falling edge, which is exactly one register stage after the stimulus. Directed sequences sit on the same-cycle collisions: set against clear, transfer against read, and timeout against status read.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int ERR_W   = 4;
  localparam int ERR_OVR = 0;
  localparam int ERR_ABT = 1;
  localparam int ERR_COL = 2;
  localparam int ERR_UND = 3;

  localparam logic [1:0] MODE_OFF    = 2'b00;
  localparam logic [1:0] MODE_TXONLY = 2'b10;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;

  function automatic logic link_on(input logic [1:0] m);
    return m != MODE_OFF;
  endfunction

  function automatic logic rx_irq_path(input logic [1:0] m);
    return (m != MODE_OFF) && (m != MODE_TXONLY);
  endfunction
endpackage

// File: rtl/spi_char_buffer.sv
module spi_char_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              rx_path,
  input  logic              take_rx,
  input  logic              load_tx,
  input  logic [DATA_W-1:0] shift_in,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              tx_empty,
  output logic              ovr_evt
);
  logic full_d;
  logic empty_d;
  logic data_en;

  always_comb begin
    data_en = capture;
    full_d  = rx_full;
    empty_d = tx_empty;
    if (capture)      full_d = 1'b1;
    else if (take_rx) full_d = 1'b0;
    if (capture)      empty_d = 1'b1;
    else if (load_tx) empty_d = 1'b0;
    ovr_evt = capture & rx_path & rx_full & ~take_rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_full  <= 1'b0;
      tx_empty <= 1'b1;
    end else begin
      if (data_en) rx_data <= shift_in;
      rx_full  <= full_d;
      tx_empty <= empty_d;
    end
  end
endmodule

// File: rtl/spi_err_flags.sv
module spi_err_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         clr_req,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    logic bit_d;
    always_comb begin
      bit_d = bit_q;
      if (clr_req && clr_mask[i]) bit_d = 1'b0;
      if (set_evt[i])             bit_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= bit_d;
    end
    assign flags[i] = bit_q;
  end
endmodule

// File: rtl/spi_irq_combine.sv
module spi_irq_combine
  import spi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             data_irq_en,
  input  logic             timer_en,
  input  logic             brg_timeout,
  input  logic             stat_rd,
  input  logic             rx_full,
  input  logic             tx_empty,
  input  logic [ERR_W-1:0] err_flags,
  output logic             timer_pend,
  output logic             irq
);
  logic pend_d;
  logic data_src;
  logic err_src;

  always_comb begin
    pend_d = timer_pend & ~stat_rd;
    if ((mode == MODE_OFF) && brg_timeout) pend_d = 1'b1;
    if (!timer_en) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timer_pend <= 1'b0;
    else        timer_pend <= pend_d;
  end

  always_comb begin
    data_src = link_on(mode) & data_irq_en &
               ((rx_full & rx_irq_path(mode)) | tx_empty);
    err_src  = link_on(mode) & (|err_flags);
    irq      = data_src | err_src | timer_pend;
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              data_irq_en,
  input  logic              timer_en,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] shift_data,
  input  logic              underrun_evt,
  input  logic              collision_evt,
  input  logic              abort_evt,
  input  logic              brg_timeout,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int TXE_BIT = DATA_W - 1;
  localparam int RXF_BIT = DATA_W - 2;

  logic              rst_meta;
  logic              rst_sync_n;
  logic              capture;
  logic              take_rx;
  logic              load_tx;
  logic              stat_rd;
  logic              stat_wr;
  logic [DATA_W-1:0] rx_data;
  logic              rx_full;
  logic              tx_empty;
  logic              ovr_evt;
  logic [ERR_W-1:0]  err_set;
  logic [ERR_W-1:0]  err_flags;
  logic              timer_pend;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    capture = link_on(mode) & xfer_done;
    take_rx = rd_en & (addr == REG_DATA);
    load_tx = wr_en & (addr == REG_DATA);
    stat_rd = rd_en & (addr == REG_STAT);
    stat_wr = wr_en & (addr == REG_STAT);
    err_set          = '0;
    err_set[ERR_UND] = link_on(mode) & underrun_evt;
    err_set[ERR_COL] = link_on(mode) & collision_evt;
    err_set[ERR_ABT] = link_on(mode) & abort_evt;
    err_set[ERR_OVR] = ovr_evt;
  end

  spi_char_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .capture  (capture),
    .rx_path  (rx_irq_path(mode)),
    .take_rx  (take_rx),
    .load_tx  (load_tx),
    .shift_in (shift_data),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .tx_empty (tx_empty),
    .ovr_evt  (ovr_evt)
  );

  spi_err_flags #(.N(ERR_W)) u_err (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_evt  (err_set),
    .clr_req  (stat_wr),
    .clr_mask (wdata[ERR_W-1:0]),
    .flags    (err_flags)
  );

  spi_irq_combine u_irq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .mode        (mode),
    .data_irq_en (data_irq_en),
    .timer_en    (timer_en),
    .brg_timeout (brg_timeout),
    .stat_rd     (stat_rd),
    .rx_full     (rx_full),
    .tx_empty    (tx_empty),
    .err_flags   (err_flags),
    .timer_pend  (timer_pend),
    .irq         (irq)
  );

  always_comb begin
    stat_word                 = '0;
    stat_word[TXE_BIT]        = tx_empty;
    stat_word[RXF_BIT]        = rx_full;
    stat_word[ERR_W-1:0]      = err_flags;
    case (addr)
      REG_DATA: rdata_d = rx_data;
      REG_STAT: rdata_d = stat_word;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata <= '0;
    else if (rd_en)   rdata <= rdata_d;
  end
endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              xfer_done,
  input logic [DATA_W-1:0] shift_data,
  input logic              underrun_evt,
  input logic              brg_timeout,
  input logic              timer_en,
  input logic              rd_en,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              tx_empty,
  input logic [3:0]        err_flags,
  input logic              timer_pend,
  input logic              irq
);
  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && xfer_done) |=> (rx_full && rx_data == $past(shift_data))); // R1
  AST_RX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0 && !(mode != 2'b00 && xfer_done)) |=> !rx_full); // R2
  AST_TXONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !tx_empty && err_flags == 4'h0 && !timer_pend) |-> !irq); // R4
  AST_DUAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && xfer_done) |=> (tx_empty && rx_full)); // R5
  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && underrun_evt) |=> err_flags[3]); // R7
  AST_TIMER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && timer_en && brg_timeout) |=> irq); // R9
  AST_OFF_HOLDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !(wr_en && addr == 2'd1)) |=> $stable(err_flags)); // R11
endmodule

bind spi_irq_status spi_irq_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .mode         (mode),
  .xfer_done    (xfer_done),
  .shift_data   (shift_data),
  .underrun_evt (underrun_evt),
  .brg_timeout  (brg_timeout),
  .timer_en     (timer_en),
  .rd_en        (rd_en),
  .wr_en        (wr_en),
  .addr         (addr),
  .rx_data      (rx_data),
  .rx_full      (rx_full),
  .tx_empty     (tx_empty),
  .err_flags    (err_flags),
  .timer_pend   (timer_pend),
  .irq          (irq)
);

// File: tb/spi_irq_status_test.sv
module spi_irq_status_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       die, ten, xfer, und, col, abt, tmo, rd_en, wr_en;
  logic [7:0] shift, wdata;
  logic [1:0] addr;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_data, m_rdata;
  logic       m_rxf, m_txe, m_tpend;
  logic [3:0] m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_status uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .data_irq_en(die), .timer_en(ten),
    .xfer_done(xfer), .shift_data(shift), .underrun_evt(und), .collision_evt(col),
    .abort_evt(abt), .brg_timeout(tmo), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic m_irq();
    logic en, rxp;
    en  = mode != 2'b00;
    rxp = en && mode != 2'b10;
    return (en && die && ((m_rxf && rxp) || m_txe)) || (en && |m_err) || m_tpend;
  endfunction

  task automatic model_step();
    logic en, rxp, rdd, rds, wrd, wrs, ovr;
    logic [7:0] st;
    logic [3:0] ev;
    en  = mode != 2'b00;
    rxp = en && mode != 2'b10;
    rdd = rd_en && addr == 2'd0;
    rds = rd_en && addr == 2'd1;
    wrd = wr_en && addr == 2'd0;
    wrs = wr_en && addr == 2'd1;
    st  = {m_txe, m_rxf, 2'b00, m_err};
    ovr = en && xfer && rxp && m_rxf && !rdd;
    ev  = {en && und, en && col, en && abt, ovr};
    if (rd_en) m_rdata = (addr == 2'd0) ? m_data : (addr == 2'd1) ? st : 8'h00;
    for (int i = 0; i < 4; i++)
      if (ev[i]) m_err[i] = 1'b1;
      else if (wrs && wdata[i]) m_err[i] = 1'b0;
    if (en && xfer) begin m_data = shift; m_rxf = 1'b1; m_txe = 1'b1; end
    else begin
      if (rdd) m_rxf = 1'b0;
      if (wrd) m_txe = 1'b0;
    end
    m_tpend = ten && ((mode == 2'b00 && tmo) || (m_tpend && !rds));
  endtask

  task automatic idle();
    xfer = 0; und = 0; col = 0; abt = 0; tmo = 0;
    rd_en = 0; wr_en = 0; addr = 0; wdata = 0; shift = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R10 irq", irq, m_irq());
    chk("R12 rdata", rdata, m_rdata);
    idle();
  endtask

  task automatic rd(input logic [1:0] a);
    rd_en = 1; addr = a; tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d; tick();
  endtask

  task automatic xf(input logic [7:0] d);
    xfer = 1; shift = d; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4177));
    rst_n = 0; mode = 0; die = 0; ten = 0; idle();
    m_data = 0; m_rdata = 0; m_rxf = 0; m_txe = 1; m_tpend = 0; m_err = 0;
    repeat (3) @(negedge clk);
    chk("R5 reset irq", irq, 0);
    chk("R5 reset rdata", rdata, 0);
    rst_n = 1;
    repeat (3) tick();
    rd(1);             chk("R5 reset status", rdata, 8'h80);

    mode = 2'b11; die = 1;
    wr(0, 8'h00);      chk("R5 tx-empty cleared by data write", irq, 0);
    xf(8'hA5);         chk("R3 data irq", irq, 1);
    rd(1);             chk("R5 both flags", rdata, 8'hC0);
    rd(0);             chk("R1 captured byte", rdata, 8'hA5);
    rd(1);             chk("R2 read clears rx-full", rdata, 8'h80);

    wr(0, 8'h00);
    xf(8'h3C); xf(8'h5A);
    rd(1);             chk("R8 overrun", rdata, 8'hC1);
    rd(0);             chk("R8 latest byte kept", rdata, 8'h5A);
    die = 0; tick();   chk("R6 error irq without data enable", irq, 1);
    wr(1, 8'h01);
    rd(1);             chk("R6 w1c", rdata, 8'h80);
    chk("R3 data enable gates irq", irq, 0);

    col = 1; tick();
    col = 1; wr(1, 8'h04);
    rd(1);             chk("R7 set beats clear", rdata, 8'h84);
    wr(1, 8'h0F);
    rd(1);             chk("R6 clear all", rdata, 8'h80);

    mode = 2'b10; die = 1;
    xf(8'h11); xf(8'h22);
    wr(0, 8'h00);      chk("R4 no rx irq in tx-only", irq, 0);
    rd(1);             chk("R4 no overrun in tx-only", rdata, 8'h40);
    rd(0);             chk("R4 byte still stored", rdata, 8'h22);

    mode = 2'b00;
    xf(8'h99); und = 1; tick();
    rd(0);             chk("R11 off ignores transfer", rdata, 8'h22);
    rd(1);             chk("R11 off ignores events", rdata, 8'h00);

    ten = 1; tmo = 1; tick();
    chk("R9 timer irq", irq, 1);
    repeat (3) tick();
    chk("R10 level holds", irq, 1);
    rd(1);             chk("R9 no status bits", rdata, 8'h00);
    chk("R9 status read clears timer", irq, 0);
    tmo = 1; rd_en = 1; addr = 1; tick();
    chk("R9 timeout beats read", irq, 1);
    ten = 0; tick();   chk("R9 timer enable low clears", irq, 0);

    rd(0); rd(2);      chk("R12 unmapped reads zero", rdata, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      if (i % 64 == 0) begin
        mode = 2'($urandom % 4); die = 1'($urandom % 2); ten = 1'($urandom % 2);
      end
      xfer  = ($urandom % 5) == 0;
      shift = 8'($urandom);
      und   = ($urandom % 23) == 0;
      col   = ($urandom % 29) == 0;
      abt   = ($urandom % 31) == 0;
      tmo   = ($urandom % 9) == 0;
      rd_en = ($urandom % 3) == 0;
      wr_en = ($urandom % 6) == 0;
      addr  = 2'($urandom % 4);
      wdata = 8'($urandom);
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule